// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches for software liveness. A counter runs on a slow watchdog clock (nominally about 1 kHz). If software does not send a restart strobe before the counter reaches the selected timeout, the block raises a system reset request. A window mode can also be switched on. In that mode each restart first opens a closed period, and a restart that arrives while the closed period is still running is treated as a fault, so it also raises a reset request.

Software programs the block through a small byte-wide register port in the bus clock domain. There is a control register holding the enable bit and the timeout code, a window register holding the window enable and the closed-period code, and a status register. Accepted configuration writes are carried into the watchdog clock domain by a toggle handshake. While that crossing is in progress a busy flag reads one, and further configuration writes are dropped. The configuration-protection unlock is reduced to a single input that permits protected writes.

Top module: `win_watchdog`

## Requirements
- R1: After reset the control, window and status registers read 0x00, address 3 reads 0x00, and the reset request is low.
- R2: The control register holds the enable bit at bit 0 and the timeout code at bits 5:2. When the watchdog is enabled and no restarts are sent, consecutive reset requests are 8 << min(code,10) watchdog-clock cycles apart. Reserved codes 11 to 15 give 8192.
- R3: Each reset request is high for exactly one bus clock cycle.
- R4: A restart strobe on kick_i, taken on its rising edge, clears the count. Restarts sent more often than the timeout produce no reset request. The timeout counts again from the last restart.
- R5: In window mode, a restart that arrives while the closed period runs raises the reset request within three bus cycles.
- R6: The window register holds bit 1 as the window enable and bits 5:2 as the closed-period code, using the same table as R2. In window mode the period after a timeout or an accepted restart is the closed period plus the open period. A restart in the open period produces no immediate reset request.
- R7: Bit 0 of the window register is the change-enable. A write to the window register changes the register only when that bit is one. The change-enable bit always reads zero.
- R8: Writes to the control and window registers are ignored while prot_ok_i is low.
- R9: An accepted configuration write while the watchdog is, or becomes, enabled sets the busy flag (status bit 0) from the next cycle. The flag clears by itself once the transfer has completed. Configuration writes made while busy is set are ignored.
- R10: A configuration write that leaves a disabled watchdog disabled does not set busy.
- R11: Status bits 7:1 read zero, and writes to the status register change nothing.
- R12: While disabled, the block raises no reset request, even when restarts are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| wdt_clk_i | input | 1 | Slow watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 window, 2 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| prot_ok_i | input | 1 | Protected configuration write permitted |
| kick_i | input | 1 | Watchdog restart strobe |
| rst_req_o | output | 1 | System reset request, one bus cycle |

## Verification
The hardest case to reach is a restart that falls inside the closed period. Getting there needs window mode, which is only reachable through a protected window write with the change-enable bit set. The closed period also has to be known to be running, even though its start is hidden behind two clock-domain crossings. The stimulus uses each timeout pulse as a time reference. Ten cycles after a pulse the closed period is certainly active, so a restart there must fault. Seventy-five cycles after a pulse the period is certainly open, so a restart there must be accepted, which shows as the next timeout moving later by a full closed plus open period.

// File: rtl/win_watchdog_pkg.sv
package win_watchdog_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int CODE_W     = 4;
  localparam int MAX_CODE   = 10;
  localparam int BASE_SHIFT = 3;
  localparam int CNT_W      = BASE_SHIFT + MAX_CODE + 1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] open_code;
    logic              win_en;
    logic [CODE_W-1:0] closed_code;
  } wdt_cfg_t;

  // reserved codes clamp to the longest period
  function automatic logic [CNT_W-1:0] period_of(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    return CNT_W'(1) << (c + BASE_SHIFT);
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import win_watchdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              prot_ok_i,
  input  logic              ack_tgl_i,
  output logic [DATA_W-1:0] rdata_o,
  output wdt_cfg_t          cfg_o,
  output logic              req_tgl_o,
  output logic              busy_o
);
  wdt_cfg_t cfg_q;
  logic     req_q;
  logic     wr_ok, wr_ctrl, wr_win, launch;
  logic     unused_wdata;

  assign busy_o  = req_q ^ ack_tgl_i;
  assign wr_ok   = we_i && prot_ok_i && !busy_o;
  assign wr_ctrl = wr_ok && (addr_i == ADDR_CTRL);
  assign wr_win  = wr_ok && (addr_i == ADDR_WIN) && wdata_i[0];
  // crossing only when the watchdog is or becomes enabled
  assign launch  = (wr_ctrl && (cfg_q.en || wdata_i[0])) || (wr_win && cfg_q.en);
  assign unused_wdata = ^{wdata_i[7:6], wdata_i[1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg_q.en        <= wdata_i[0];
        cfg_q.open_code <= wdata_i[5:2];
      end
      if (wr_win) begin
        cfg_q.win_en      <= wdata_i[1];
        cfg_q.closed_code <= wdata_i[5:2];
      end
      req_q <= req_q ^ launch;
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {2'b00, cfg_q.open_code, 1'b0, cfg_q.en};
      ADDR_WIN:  rdata_o = {2'b00, cfg_q.closed_code, cfg_q.win_en, 1'b0};
      ADDR_STAT: rdata_o = {{(DATA_W-1){1'b0}}, busy_o};
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign req_tgl_o = req_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import win_watchdog_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_tgl_i,
  input  wdt_cfg_t cfg_i,
  input  logic     kick_tgl_i,
  output logic     ack_tgl_o,
  output logic     kick_ack_o,
  output logic     closed_o,
  output logic     exp_tgl_o
);
  wdt_cfg_t          cfg_q, cfg_nx;
  logic              req_seen_q, kick_seen_q, closed_q, exp_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic              cfg_upd, restart, term;

  assign cfg_upd = req_tgl_i ^ req_seen_q;
  assign restart = cfg_upd || (kick_tgl_i ^ kick_seen_q);
  assign cfg_nx  = cfg_upd ? cfg_i : cfg_q;
  assign limit   = period_of(closed_q ? cfg_q.closed_code : cfg_q.open_code);
  assign term    = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      req_seen_q  <= 1'b0;
      kick_seen_q <= 1'b0;
      closed_q    <= 1'b0;
      exp_q       <= 1'b0;
      cnt_q       <= '0;
    end else begin
      req_seen_q  <= req_tgl_i;
      kick_seen_q <= kick_tgl_i;
      cfg_q       <= cfg_nx;
      if (!cfg_nx.en) begin
        cnt_q    <= '0;
        closed_q <= 1'b0;
      end else if (restart) begin
        cnt_q    <= '0;
        closed_q <= cfg_nx.win_en;
      end else if (term && closed_q) begin
        cnt_q    <= '0;
        closed_q <= 1'b0;
      end else if (term) begin
        cnt_q    <= '0;
        closed_q <= cfg_q.win_en;
        exp_q    <= ~exp_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ack_tgl_o  = req_seen_q;
  assign kick_ack_o = kick_seen_q;
  assign closed_o   = closed_q;
  assign exp_tgl_o  = exp_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import win_watchdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              wdt_clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              prot_ok_i,
  input  logic              kick_i,
  output logic              rst_req_o
);
  wdt_cfg_t cfg;
  logic req_tgl, busy;
  logic ack_tgl_s, kick_ack_s, closed_s, exp_s;
  logic req_tgl_w, kick_tgl_w;
  logic ack_tgl_w, kick_ack_w, closed_w, exp_w;
  logic kick_d_q, kick_q, exp_d_q, rst_req_q;
  logic kick_evt, kick_pend, violation, kick_fire, timeout;

  wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .prot_ok_i (prot_ok_i),
    .ack_tgl_i (ack_tgl_s),
    .rdata_o   (bus_rdata_o),
    .cfg_o     (cfg),
    .req_tgl_o (req_tgl),
    .busy_o    (busy)
  );

  wdt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_to_slow (
    .clk_i  (wdt_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({req_tgl, kick_q}),
    .q_o    ({req_tgl_w, kick_tgl_w})
  );

  wdt_core u_core (
    .clk_i      (wdt_clk_i),
    .rst_ni     (rst_ni),
    .req_tgl_i  (req_tgl_w),
    .cfg_i      (cfg),
    .kick_tgl_i (kick_tgl_w),
    .ack_tgl_o  (ack_tgl_w),
    .kick_ack_o (kick_ack_w),
    .closed_o   (closed_w),
    .exp_tgl_o  (exp_w)
  );

  wdt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ack_tgl_w, kick_ack_w, closed_w, exp_w}),
    .q_o    ({ack_tgl_s, kick_ack_s, closed_s, exp_s})
  );

  assign kick_evt  = kick_i && !kick_d_q;
  assign kick_pend = kick_q ^ kick_ack_s;
  assign violation = kick_evt && cfg.en && closed_s;
  assign kick_fire = kick_evt && cfg.en && !closed_s && !kick_pend;
  assign timeout   = exp_s ^ exp_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_d_q  <= 1'b0;
      kick_q    <= 1'b0;
      exp_d_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      kick_d_q  <= kick_i;
      kick_q    <= kick_q ^ kick_fire;
      exp_d_q   <= exp_s;
      rst_req_q <= (violation || timeout) && !rst_req_q;
    end
  end

  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/win_watchdog_checker.sv
module win_watchdog_checker
  import win_watchdog_pkg::*;
#(
  parameter int BUSY_LIMIT = 1 << 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              prot_ok_i,
  input logic              rst_req_o,
  input logic              busy,
  input wdt_cfg_t          cfg
);
  logic [31:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else         busy_cnt_q <= busy ? busy_cnt_q + 1 : '0;
  end

  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && !prot_ok_i) |=> $stable(cfg));

  assert_busy_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(bus_we_i && prot_ok_i));

  assert_busy_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q < BUSY_LIMIT);

  assert_busy_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(cfg));

  assert_status_rsvd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_STAT) |-> (bus_rdata_o[DATA_W-1:1] == '0));

  assert_chg_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_WIN) |-> !bus_rdata_o[0]);
endmodule

bind win_watchdog win_watchdog_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .prot_ok_i   (prot_ok_i),
  .rst_req_o   (rst_req_o),
  .busy        (busy),
  .cfg         (cfg)
);

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  logic       clk = 1'b0;
  logic       wdt_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       prot = 1'b0;
  logic       kick = 1'b0;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int wide   = 0;
  logic prev_rst = 1'b0;

  always #10 clk = ~clk;
  initial begin
    #5;
    forever #10 wdt_clk = ~wdt_clk;
  end

  win_watchdog uut (
    .clk_i       (clk),
    .wdt_clk_i   (wdt_clk),
    .rst_ni      (rst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .prot_ok_i   (prot),
    .kick_i      (kick),
    .rst_req_o   (rst_req)
  );

  always @(negedge clk) begin
    if (rst_req && prev_rst) wide++;
    if (rst_req && !prev_rst) pulses++;
    prev_rst = rst_req;
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic p);
    addr = a; wdata = d; prot = p; we = 1'b1;
    @(negedge clk);
    we = 1'b0; prot = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic pulse_kick;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_idle;
    int v;
    for (int i = 0; i < 100; i++) begin
      rd(2'd2, v);
      if (v[0] == 1'b0) return;
      @(negedge clk);
    end
  endtask

  task automatic wait_rst(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req) begin
        n = i;
        return;
      end
    end
  endtask

  function automatic int period(input int c);
    return 8 << ((c > 10) ? 10 : c);
  endfunction

  initial begin
    int v, n, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 read addr %0d", a), v, 0);
    end
    chk("R1 rst_req low", int'(rst_req), 0);

    // R10 disabled write raises no busy
    wr(2'd0, 8'h14, 1'b1);
    rd(2'd2, v);
    chk("R10 busy after disabled write", v, 0);
    rd(2'd0, v);
    chk("R10 ctrl written", v, 8'h14);

    // R8 unprotected writes ignored
    wr(2'd0, 8'h01, 1'b0);
    rd(2'd0, v);
    chk("R8 ctrl unchanged", v, 8'h14);
    wr(2'd1, 8'h0F, 1'b0);
    rd(2'd1, v);
    chk("R8 window unchanged", v, 0);

    // R7 change-enable gating
    wr(2'd1, 8'h0E, 1'b1);
    rd(2'd1, v);
    chk("R7 write without change-enable", v, 0);
    wr(2'd1, 8'h0F, 1'b1);
    rd(2'd1, v);
    chk("R7 write with change-enable", v, 8'h0E);
    wr(2'd1, 8'h01, 1'b1);
    rd(2'd1, v);
    chk("R7 window cleared", v, 0);

    // R9 busy on enabling write, writes during busy dropped
    wr(2'd0, 8'h01, 1'b1);
    rd(2'd2, v);
    chk("R9 busy set", v, 1);
    wr(2'd0, 8'h05, 1'b1);
    rd(2'd0, v);
    chk("R9 write during busy ignored", v, 8'h01);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      rd(2'd2, v);
      if (v == 0) break;
      n++;
      @(negedge clk);
    end
    chk_rng("R9 busy clears", n, 1, 20);

    // R2 period sweep
    for (int c = 0; c < 16; c++) begin
      if (c <= 11 || c == 15) begin
        wait_idle();
        wr(2'd0, 8'(1 | (c << 2)), 1'b1);
        wait_idle();
        wait_rst(period(c) + 60, n);
        chk_rng($sformatf("R2 first timeout code %0d", c), n, 1, period(c) + 60);
        wait_rst(period(c) + 60, n);
        chk_rng($sformatf("R2 period code %0d", c), n, period(c) - 1, period(c) + 1);
      end
    end

    // R12 disabled: no reset even with kicks
    wait_idle();
    wr(2'd0, 8'h0C, 1'b1);
    wait_idle();
    p0 = pulses;
    for (int i = 0; i < 5; i++) begin
      repeat (60) @(negedge clk);
      pulse_kick();
    end
    repeat (100) @(negedge clk);
    chk("R12 no reset while disabled", pulses - p0, 0);

    // R4 regular kicks keep it quiet
    wr(2'd0, 8'h0D, 1'b1);
    wait_idle();
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin
      repeat (40) @(negedge clk);
      pulse_kick();
    end
    chk("R4 no reset with regular kicks", pulses - p0, 0);
    wait_rst(200, n);
    chk_rng("R4 timeout from last kick", n, 64, 75);

    // R6 window mode: closed 64 + open 32
    wait_idle();
    wr(2'd0, 8'h09, 1'b1);
    wait_idle();
    wr(2'd1, 8'h0F, 1'b1);
    wait_idle();
    wait_rst(400, n);
    chk_rng("R6 first window timeout", n, 1, 400);
    wait_rst(200, n);
    chk_rng("R6 closed plus open period", n, 95, 97);

    // R5 kick inside closed window
    repeat (10) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk("R5 reset one cycle after closed kick", int'(rst_req), 1);
    wait_rst(200, n);
    chk_rng("R5 timeout unaffected by faulty kick", n, 80, 90);

    // R6 kick in open window restarts
    repeat (75) @(negedge clk);
    p0 = pulses;
    pulse_kick();
    repeat (10) @(negedge clk);
    chk("R6 open kick gives no reset", pulses - p0, 0);
    wait_rst(300, n);
    chk_rng("R6 restart from open kick", n + 11, 96, 107);

    // R11 status reserved and read-only
    wait_idle();
    wr(2'd2, 8'hFF, 1'b1);
    rd(2'd2, v);
    chk("R11 status after write", v, 0);
    rd(2'd0, v);
    chk("R11 ctrl untouched by status write", v, 8'h09);
    rd(2'd1, v);
    chk("R11 window untouched by status write", v, 8'h0E);
    rd(2'd3, v);
    chk("R11 unused address reads zero", v, 0);

    // R3 pulse width across the run
    chk("R3 all pulses one cycle", wide, 0);
    summary();
  end
endmodule